// File: doc/BRIEF.md
# Hexadecimal Floating-Point Add/Subtract Unit

This unit adds or subtracts two 32-bit floating-point words whose exponent scales by powers of sixteen. Each word holds a sign in bit 31, a 7-bit excess-64 exponent in bits 30:24, and a six-hex-digit fraction in bits 23:0. The value of a word is 0.fraction × 16^(exponent − 64). One operand is the accumulator value and the other is the addend. A subtract request is handled as an add after the addend's sign is inverted.

The datapath is sequential and works in whole hex digits. First the operand with the smaller exponent is shifted right one digit per clock, and the last digit shifted out is kept as a guard digit. The fractions are then combined in two's complement and the sum is turned back into sign and magnitude. Last, the result is renormalized one digit per clock. A carry into a seventh digit moves the fraction right. Leading zero digits move it left, and each left move brings the guard digit in at the bottom. Exponent overflow or underflow forces the result word to zero and raises a flag.

Operands come in through a valid/ready handshake. `in_ready` is high only while the unit is idle. A request transfers on a rising edge where `in_valid` and `in_ready` are both high, and `in_valid` has no effect at any other time. The unit cannot stall the output. `out_valid` is high for exactly one cycle, and `out_result`, `out_ovf` and `out_unf` keep their values until the next result is produced.

Top module: `hex_fp_addsub`

## Requirements
- R1: `in_ready` is 1 only when the unit is idle. A request transfers when `in_valid` and `in_ready` are both 1 at a rising edge, and `in_valid` or the operand inputs have no effect while `in_ready` is 0.
- R2: `out_valid` is high for one cycle per operation. The result word and both flags keep their values until the next `out_valid`.
- R3: When `in_sub` is 1, the result equals the add of the accumulator and the addend with the addend's bit 31 inverted.
- R4: If the addend fraction (bits 23:0) is zero, the result is the accumulator word unchanged and is not renormalized. `out_valid` comes one cycle after the transfer.
- R5: If the addend fraction is nonzero and the accumulator fraction is zero, the result is the addend word, with bit 31 inverted for a subtract. `out_valid` comes one cycle after the transfer.
- R6: Two normalized operands with equal exponents and same-sign fractions whose sum needs no renormalization give `out_valid` 4 cycles after the transfer. A result needs at most 16 cycles.
- R7: A negative sum is stored as its magnitude with bit 31 set.
- R8: If the exponents differ by 6 or more, the operand with the smaller exponent counts as zero, and the result takes the exponent and fraction of the other operand.
- R9: If the exponents differ by 1 to 5, the smaller operand moves right one hex digit per cycle. The last digit moved out is kept as a guard digit below the fraction.
- R10: A sum that carries into a seventh hex digit moves right one digit, and the exponent goes up by one.
- R11: While the top hex digit of the fraction (bits 23:20 of the result) is zero, the fraction moves left one digit, the guard digit enters at the bottom, and the exponent goes down by one.
- R12: A zero sum gives the word 0x00000000.
- R13: If a right renormalization would take the exponent above 127, the result is 0x00000000 and `out_ovf` is 1 with `out_valid`.
- R14: If a left renormalization is needed at exponent 0, the result is 0x00000000 and `out_unf` is 1 with `out_valid`. The two flags are never high together, and both are 0 for any other result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle, request can transfer |
| in_sub | input | 1 | 1 selects subtract, 0 selects add |
| in_acc | input | 32 | Accumulator operand word |
| in_opd | input | 32 | Addend operand word |
| out_valid | output | 1 | One-cycle result strobe |
| out_result | output | 32 | Result word, held between strobes |
| out_ovf | output | 1 | Exponent overflow on the last result |
| out_unf | output | 1 | Exponent underflow on the last result |

## Verification
Latency is counted in rising edges from the transfer edge to the edge that raises `out_valid`. A zero-operand shortcut takes 1 edge. A zero sum takes 3 + k edges, where k is the number of alignment shifts. Any other result takes 4 + k + n edges, where n is the number of renormalization shifts; an overflow or underflow ends the operation at the shift that would have taken the exponent out of range. The bench drives inputs and samples outputs on falling edges. It counts edges until `out_valid` appears and compares the count with the value worked out for each vector. On the following falling edge it checks that the strobe has dropped and the result is unchanged.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
  localparam int HFP_EXP_W  = 7;
  localparam int HFP_DIGITS = 6;
  localparam int HFP_NIB    = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_ADD,
    ST_NORM
  } hfp_state_e;
endpackage

// File: rtl/hfp_align.sv
module hfp_align #(
  parameter int EXP_W  = hfp_pkg::HFP_EXP_W,
  parameter int DIGITS = hfp_pkg::HFP_DIGITS,
  localparam int NIB   = hfp_pkg::HFP_NIB,
  localparam int EXT_W = (DIGITS + 1) * NIB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [EXP_W-1:0] ld_ea,
  input  logic [EXP_W-1:0] ld_eb,
  input  logic [EXT_W-1:0] ld_ma,
  input  logic [EXT_W-1:0] ld_mb,
  output logic [EXP_W-1:0] ea,
  output logic [EXP_W-1:0] eb,
  output logic [EXT_W-1:0] ma,
  output logic [EXT_W-1:0] mb,
  output logic             aligned
);
  localparam logic [EXP_W:0] FAR_GAP = (EXP_W + 1)'(DIGITS);

  logic [EXP_W:0] gap_ab, gap_ba, gap_now;
  logic           a_far, b_far;

  always_comb begin
    gap_ab  = {1'b0, ld_ea} - {1'b0, ld_eb};
    gap_ba  = {1'b0, ld_eb} - {1'b0, ld_ea};
    a_far   = (ld_eb > ld_ea) && (gap_ba >= FAR_GAP);
    b_far   = (ld_ea > ld_eb) && (gap_ab >= FAR_GAP);
    aligned = (ea == eb);
    gap_now = (ea > eb) ? ({1'b0, ea} - {1'b0, eb}) : ({1'b0, eb} - {1'b0, ea});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea <= '0;
      eb <= '0;
      ma <= '0;
      mb <= '0;
    end else if (load) begin
      ea <= a_far ? ld_eb : ld_ea;
      eb <= b_far ? ld_ea : ld_eb;
      ma <= a_far ? '0 : ld_ma;
      mb <= b_far ? '0 : ld_mb;
    end else if (step && !aligned) begin
      if (ea < eb) begin
        ma <= ma >> NIB;
        ea <= ea + 1'b1;
      end else begin
        mb <= mb >> NIB;
        eb <= eb + 1'b1;
      end
    end
  end

  AST_GAP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> (gap_now < FAR_GAP)); // R8

  AST_ALIGN_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !aligned && !load) |=> (gap_now < $past(gap_now))); // R9
endmodule

// File: rtl/hfp_sum.sv
module hfp_sum #(
  parameter int DIGITS = hfp_pkg::HFP_DIGITS,
  localparam int NIB   = hfp_pkg::HFP_NIB,
  localparam int EXT_W = (DIGITS + 1) * NIB,
  localparam int SUM_W = EXT_W + NIB
) (
  input  logic             sa,
  input  logic             sb,
  input  logic [EXT_W-1:0] ma,
  input  logic [EXT_W-1:0] mb,
  output logic             zero,
  output logic             sign,
  output logic [SUM_W-1:0] mag
);
  localparam int PAD = SUM_W + 1 - EXT_W;

  logic signed [SUM_W:0] ta, tb, s;

  always_comb begin
    ta   = $signed({{PAD{1'b0}}, ma});
    tb   = $signed({{PAD{1'b0}}, mb});
    if (sa) ta = -ta;
    if (sb) tb = -tb;
    s    = ta + tb;
    zero = (s == '0);
    sign = s[SUM_W];
    mag  = sign ? SUM_W'(-s) : s[SUM_W-1:0];
  end
endmodule

// File: rtl/hfp_norm.sv
module hfp_norm #(
  parameter int EXP_W  = hfp_pkg::HFP_EXP_W,
  parameter int DIGITS = hfp_pkg::HFP_DIGITS,
  localparam int NIB   = hfp_pkg::HFP_NIB,
  localparam int EXT_W = (DIGITS + 1) * NIB,
  localparam int SUM_W = EXT_W + NIB
) (
  input  logic [SUM_W-1:0] mag,
  input  logic [EXP_W-1:0] exp_in,
  output logic [SUM_W-1:0] mag_nx,
  output logic [EXP_W-1:0] exp_nx,
  output logic             fin,
  output logic             ovf,
  output logic             unf
);
  localparam logic [EXP_W-1:0] EXP_TOP = '1;

  logic carry_dig, lead_zero;

  always_comb begin
    carry_dig = |mag[SUM_W-1 -: NIB];
    lead_zero = ~|mag[EXT_W-1 -: NIB];
    mag_nx    = mag;
    exp_nx    = exp_in;
    fin       = 1'b0;
    ovf       = 1'b0;
    unf       = 1'b0;
    if (carry_dig) begin
      if (exp_in == EXP_TOP) begin
        ovf = 1'b1;
      end else begin
        mag_nx = mag >> NIB;
        exp_nx = exp_in + 1'b1;
      end
    end else if (lead_zero) begin
      if (exp_in == '0) begin
        unf = 1'b1;
      end else begin
        mag_nx = mag << NIB;
        exp_nx = exp_in - 1'b1;
      end
    end else begin
      fin = 1'b1;
    end
  end
endmodule

// File: rtl/hex_fp_addsub.sv
module hex_fp_addsub #(
  parameter int EXP_W   = hfp_pkg::HFP_EXP_W,
  parameter int DIGITS  = hfp_pkg::HFP_DIGITS,
  localparam int NIB    = hfp_pkg::HFP_NIB,
  localparam int MANT_W = DIGITS * NIB,
  localparam int WORD_W = 1 + EXP_W + MANT_W,
  localparam int EXT_W  = MANT_W + NIB,
  localparam int SUM_W  = EXT_W + NIB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sub,
  input  logic [WORD_W-1:0] in_acc,
  input  logic [WORD_W-1:0] in_opd,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_result,
  output logic              out_ovf,
  output logic              out_unf
);
  import hfp_pkg::*;

  hfp_state_e state;

  logic              acc_sign, opd_sign;
  logic [EXP_W-1:0]  acc_exp, opd_exp;
  logic [MANT_W-1:0] acc_frac, opd_frac;
  logic              accept, opd_zero, acc_zero, take_long;

  logic              sa, sb;
  logic [EXP_W-1:0]  ea, eb;
  logic [EXT_W-1:0]  ma, mb;
  logic              aligned;

  logic              sum_zero, sum_sign;
  logic [SUM_W-1:0]  sum_mag;

  logic              rsign;
  logic [SUM_W-1:0]  nmag, nmag_nx;
  logic [EXP_W-1:0]  nexp, nexp_nx;
  logic              n_fin, n_ovf, n_unf;

  always_comb begin
    acc_sign  = in_acc[WORD_W-1];
    acc_exp   = in_acc[WORD_W-2 -: EXP_W];
    acc_frac  = in_acc[MANT_W-1:0];
    opd_sign  = in_opd[WORD_W-1] ^ in_sub;
    opd_exp   = in_opd[WORD_W-2 -: EXP_W];
    opd_frac  = in_opd[MANT_W-1:0];
    in_ready  = (state == ST_IDLE);
    accept    = in_valid && in_ready;
    opd_zero  = (opd_frac == '0);
    acc_zero  = (acc_frac == '0);
    take_long = accept && !opd_zero && !acc_zero;
  end

  hfp_align #(.EXP_W(EXP_W), .DIGITS(DIGITS)) u_align (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take_long),
    .step    (state == ST_ALIGN),
    .ld_ea   (acc_exp),
    .ld_eb   (opd_exp),
    .ld_ma   ({acc_frac, {NIB{1'b0}}}),
    .ld_mb   ({opd_frac, {NIB{1'b0}}}),
    .ea      (ea),
    .eb      (eb),
    .ma      (ma),
    .mb      (mb),
    .aligned (aligned)
  );

  hfp_sum #(.DIGITS(DIGITS)) u_sum (
    .sa   (sa),
    .sb   (sb),
    .ma   (ma),
    .mb   (mb),
    .zero (sum_zero),
    .sign (sum_sign),
    .mag  (sum_mag)
  );

  hfp_norm #(.EXP_W(EXP_W), .DIGITS(DIGITS)) u_norm (
    .mag    (nmag),
    .exp_in (nexp),
    .mag_nx (nmag_nx),
    .exp_nx (nexp_nx),
    .fin    (n_fin),
    .ovf    (n_ovf),
    .unf    (n_unf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      sa         <= 1'b0;
      sb         <= 1'b0;
      rsign      <= 1'b0;
      nmag       <= '0;
      nexp       <= '0;
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ovf    <= 1'b0;
      out_unf    <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (opd_zero) begin
              out_valid  <= 1'b1;
              out_result <= in_acc;
              out_ovf    <= 1'b0;
              out_unf    <= 1'b0;
            end else if (acc_zero) begin
              out_valid  <= 1'b1;
              out_result <= {opd_sign, in_opd[WORD_W-2:0]};
              out_ovf    <= 1'b0;
              out_unf    <= 1'b0;
            end else begin
              sa    <= acc_sign;
              sb    <= opd_sign;
              state <= ST_ALIGN;
            end
          end
        end
        ST_ALIGN: begin
          if (aligned) state <= ST_ADD;
        end
        ST_ADD: begin
          if (sum_zero) begin
            out_valid  <= 1'b1;
            out_result <= '0;
            out_ovf    <= 1'b0;
            out_unf    <= 1'b0;
            state      <= ST_IDLE;
          end else begin
            rsign <= sum_sign;
            nmag  <= sum_mag;
            nexp  <= ea;
            state <= ST_NORM;
          end
        end
        default: begin
          if (n_ovf || n_unf) begin
            out_valid  <= 1'b1;
            out_result <= '0;
            out_ovf    <= n_ovf;
            out_unf    <= n_unf;
            state      <= ST_IDLE;
          end else if (n_fin) begin
            out_valid  <= 1'b1;
            out_result <= {rsign, nexp, nmag[EXT_W-1:NIB]};
            out_ovf    <= 1'b0;
            out_unf    <= 1'b0;
            state      <= ST_IDLE;
          end else begin
            nmag <= nmag_nx;
            nexp <= nexp_nx;
          end
        end
      endcase
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid || !in_ready)); // R1

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_valid) |=> !out_valid); // R2

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable({out_result, out_ovf, out_unf})); // R2

  AST_ERROR_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_ovf || out_unf)) |-> (out_result == '0)); // R13

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_ovf, out_unf})); // R14
endmodule

// File: tb/test_hex_fp_addsub.sv
module test_hex_fp_addsub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sub = 1'b0;
  logic [31:0] in_acc = '0;
  logic [31:0] in_opd = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_ovf, out_unf;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  hex_fp_addsub i_hex_fp_addsub (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_sub     (in_sub),
    .in_acc     (in_acc),
    .in_opd     (in_opd),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_ovf    (out_ovf),
    .out_unf    (out_unf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // elat = 0 leaves latency unchecked; noise keeps in_valid high with junk while busy
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic sub,
                        input logic [31:0] er, input logic eo, input logic eu,
                        input int elat, input string req, input bit noise);
    int lat;
    @(negedge clk);
    chk(in_ready === 1'b1, "R1", "ready when idle", {31'b0, in_ready}, 32'd1);
    in_acc = a; in_opd = b; in_sub = sub; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (noise) begin
      in_acc = 32'h7F7F7F7F; in_opd = 32'h01010101; in_sub = ~sub;
    end else begin
      in_valid = 1'b0;
    end
    lat = 1;
    while (!out_valid && lat < 40) begin
      if (noise) chk(in_ready === 1'b0, "R1", "ready low while busy", {31'b0, in_ready}, 32'd0);
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    chk(out_valid === 1'b1, req, "strobe seen", {31'b0, out_valid}, 32'd1);
    chk(out_result === er, req, "result", out_result, er);
    chk({out_ovf, out_unf} === {eo, eu}, req, "flags", {30'b0, out_ovf, out_unf}, {30'b0, eo, eu});
    chk(lat <= 16, "R6", "latency bound", 32'(lat), 32'd16);
    if (elat > 0) chk(lat == elat, req, "latency", 32'(lat), 32'(elat));
    @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R2", "strobe one cycle", {31'b0, out_valid}, 32'd0);
    chk(out_result === er, "R2", "result held", out_result, er);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R1", "reset handshake",
        {30'b0, in_ready, out_valid}, 32'd2);
    chk(out_result === 32'h0 && out_ovf === 1'b0 && out_unf === 1'b0, "R2", "reset outputs",
        out_result, 32'h0);
  endtask

  task automatic t_plain_add;   // R6
    run_op(32'h41100000, 32'h41200000, 1'b0, 32'h41300000, 1'b0, 1'b0, 4, "R6", 1'b0);
  endtask

  task automatic t_carry;       // R10
    run_op(32'h41800000, 32'h41A00000, 1'b0, 32'h42120000, 1'b0, 1'b0, 5, "R10", 1'b0);
  endtask

  task automatic t_cancel;      // R3 and R11
    run_op(32'h41123456, 32'h41123400, 1'b1, 32'h3D560000, 1'b0, 1'b0, 8, "R11", 1'b0);
  endtask

  task automatic t_negative;    // R7 with R3
    run_op(32'h41100000, 32'h41300000, 1'b1, 32'hC1200000, 1'b0, 1'b0, 4, "R7", 1'b0);
  endtask

  task automatic t_guard;       // R9: five-digit shift, guard re-enters on left shift
    run_op(32'h41100001, 32'h3C123400, 1'b1, 32'h40FFFFFE, 1'b0, 1'b0, 10, "R9", 1'b0);
    run_op(32'h40100000, 32'h41100000, 1'b0, 32'h41110000, 1'b0, 1'b0, 5, "R9", 1'b0);
  endtask

  task automatic t_far;         // R8
    run_op(32'h45123456, 32'h3F654321, 1'b0, 32'h45123456, 1'b0, 1'b0, 4, "R8", 1'b0);
    run_op(32'h40111111, 32'h46222222, 1'b0, 32'h46222222, 1'b0, 1'b0, 4, "R8", 1'b0);
  endtask

  task automatic t_zero_opd;    // R4
    run_op(32'h41300000, 32'h00000000, 1'b0, 32'h41300000, 1'b0, 1'b0, 1, "R4", 1'b0);
    run_op(32'h4100ABCD, 32'h55000000, 1'b1, 32'h4100ABCD, 1'b0, 1'b0, 1, "R4", 1'b0);
  endtask

  task automatic t_zero_acc;    // R5 with R3
    run_op(32'h00000000, 32'h42123456, 1'b1, 32'hC2123456, 1'b0, 1'b0, 1, "R5", 1'b0);
    run_op(32'h00000000, 32'h42123456, 1'b0, 32'h42123456, 1'b0, 1'b0, 1, "R5", 1'b0);
  endtask

  task automatic t_zero_sum;    // R12
    run_op(32'hC1555555, 32'h41555555, 1'b0, 32'h00000000, 1'b0, 1'b0, 3, "R12", 1'b0);
  endtask

  task automatic t_overflow;    // R13
    run_op(32'h7F800000, 32'h7F800000, 1'b0, 32'h00000000, 1'b1, 1'b0, 4, "R13", 1'b0);
  endtask

  task automatic t_underflow;   // R14
    run_op(32'h00100000, 32'h000F0000, 1'b1, 32'h00000000, 1'b0, 1'b1, 4, "R14", 1'b0);
  endtask

  task automatic t_busy_ignore; // R1: junk requests while busy leave the result alone
    run_op(32'h41800000, 32'h41A00000, 1'b0, 32'h42120000, 1'b0, 1'b0, 5, "R1", 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain_add();
    t_carry();
    t_cancel();
    t_negative();
    t_guard();
    t_far();
    t_overflow();
    t_zero_opd();
    t_underflow();
    t_zero_acc();
    t_zero_sum();
    t_busy_ignore();
    t_plain_add();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule